// File: doc/BRIEF.md
# Interface Power State Controller

This block sequences the power state of a serial timeslot interface. Its three states are power-down, power-up and activation-requested. It reports the current state to the controlling processor as a 4-bit indication code. It also drives the enables for the interface bit clock and frame sync. The processor sends decoded 4-bit commands with a valid qualifier. A timing command powers the interface up. An activate request asks the line interface to start activation, which the block signals with a one-cycle strobe. A deactivation command returns the block to power-down.

A clock-stop configuration input selects how power-down behaves. With clock-stop disabled, power-down and power-up differ only in the reported code, and the clocks keep running. With clock-stop enabled, power-down gates both enables off. The only ways out are then the software power-up input or clearing the configuration input. While stopped, the timing and activate commands are not accepted. Enables change only on a frame-boundary tick, so the outputs never carry a partial frame.

Clock-stop takes effect only after the configuration input has been seen to go from 0 to 1 after reset. This means the interface clocks are always running when reset is released.

Top module: `ifc_pwr_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the state is power-down, the indication is 1111, both enables are 1 and the strobe is 0.
- R2: The indication code is 1111 in power-down, 0111 in power-up and 0100 in activation-requested. The code is registered and changes in the cycle after the accepted command.
- R3: Commands are accepted only when the valid input is 1. The codes are timing = 0000, activate = 1000 and deactivate = 1111. Any other code leaves the state unchanged.
- R4: With clock-stop not armed, a timing command moves power-down to power-up, and the enables stay 1 in every state.
- R5: An activate command moves power-up to activation-requested in either mode, and moves power-down directly to activation-requested when clock-stop is not armed. Deactivate moves power-up or activation-requested to power-down.
- R6: The activation strobe is 1 for exactly one cycle, the cycle after an accepted activate command. An activate command in activation-requested gives no strobe.
- R7: Clock-stop is armed only when the configuration input goes from 0 to 1 after reset. A configuration input held at 1 through reset does not arm it. Clock-stop disarms whenever the input is 0.
- R8: With clock-stop armed in power-down, the enables turn off. Timing and activate commands are ignored in this state. The block moves to power-up when the software power-up input is 1 or the configuration input is 0.
- R9: Both enables change only in the cycle after a frame tick.
- R10: When turning on, the clock enable rises at one frame tick and the frame enable rises at the next. When turning off, the frame enable falls first and the clock enable falls at the next tick. The frame enable is never 1 while the clock enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| clk_stop_cfg_i | input | 1 | Clock-stop configuration |
| sw_pwr_up_i | input | 1 | Software power-up request (level) |
| cmd_valid_i | input | 1 | Command qualifier |
| cmd_i | input | 4 | Decoded command code |
| frame_tick_i | input | 1 | Frame-boundary pulse |
| clk_en_o | output | 1 | Interface bit-clock enable |
| frm_en_o | output | 1 | Interface frame-sync enable |
| ind_o | output | 4 | State indication code |
| act_req_o | output | 1 | Line-activation request strobe |

## Verification
The bench builds the block with its default 4-bit codes and the default command and indication values. With these defaults, every legal command is reached, along with one unused code (0101). A frame tick every fourth cycle lets the two-tick enable ordering complete within a short window after each state change. A long pseudo-random phase toggles the configuration and power-up inputs. This brings arming and disarming into every state and lines up commands with frame ticks.

// File: rtl/ipsc_pkg.sv
package ipsc_pkg;
  typedef enum logic [1:0] {
    PS_DOWN = 2'd0,
    PS_UP   = 2'd1,
    PS_ACT  = 2'd2
  } pstate_t;
endpackage

// File: rtl/ipsc_mode_track.sv
module ipsc_mode_track (
  input  logic clk_i,
  input  logic rst_i,
  input  logic cfg_i,
  output logic armed_o
);
  logic cfg_q;
  logic armed_q;

  // cfg_q resets high so a level already present at reset is not an edge
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cfg_q   <= 1'b1;
      armed_q <= 1'b0;
    end else begin
      cfg_q   <= cfg_i;
      armed_q <= cfg_i & (armed_q | ~cfg_q);
    end
  end

  assign armed_o = armed_q;

  p_arm_needs_cfg_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(armed_q) |-> $past(cfg_i) && !$past(cfg_q));
endmodule

// File: rtl/ipsc_state_fsm.sv
module ipsc_state_fsm
  import ipsc_pkg::*;
#(
  parameter int CODE_W = 4,
  parameter logic [CODE_W-1:0] CMD_TIM  = 4'b0000,
  parameter logic [CODE_W-1:0] CMD_AR   = 4'b1000,
  parameter logic [CODE_W-1:0] CMD_DI   = 4'b1111,
  parameter logic [CODE_W-1:0] IND_DOWN = 4'b1111,
  parameter logic [CODE_W-1:0] IND_UP   = 4'b0111,
  parameter logic [CODE_W-1:0] IND_ACT  = 4'b0100
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              armed_i,
  input  logic              cfg_i,
  input  logic              sw_pwr_up_i,
  input  logic              cmd_valid_i,
  input  logic [CODE_W-1:0] cmd_i,
  output pstate_t           state_o,
  output logic [CODE_W-1:0] ind_o,
  output logic              strb_o
);
  pstate_t           state_q, nxt;
  logic              accept;
  logic [CODE_W-1:0] ind_q;
  logic              strb_q;
  logic              is_tim, is_ar, is_di;

  assign is_tim = cmd_valid_i && (cmd_i == CMD_TIM);
  assign is_ar  = cmd_valid_i && (cmd_i == CMD_AR);
  assign is_di  = cmd_valid_i && (cmd_i == CMD_DI);

  function automatic logic [CODE_W-1:0] ind_of(pstate_t s);
    case (s)
      PS_UP:   ind_of = IND_UP;
      PS_ACT:  ind_of = IND_ACT;
      default: ind_of = IND_DOWN;
    endcase
  endfunction

  always_comb begin
    nxt    = state_q;
    accept = 1'b0;
    case (state_q)
      PS_DOWN: begin
        if (armed_i) begin
          if (sw_pwr_up_i || !cfg_i) nxt = PS_UP;
        end else if (is_tim) begin
          nxt = PS_UP;
        end else if (is_ar) begin
          nxt    = PS_ACT;
          accept = 1'b1;
        end
      end
      PS_UP: begin
        if (is_di) begin
          nxt = PS_DOWN;
        end else if (is_ar) begin
          nxt    = PS_ACT;
          accept = 1'b1;
        end
      end
      PS_ACT: begin
        if (is_di) nxt = PS_DOWN;
      end
      default: nxt = PS_DOWN;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      state_q <= PS_DOWN;
      ind_q   <= IND_DOWN;
      strb_q  <= 1'b0;
    end else begin
      state_q <= nxt;
      ind_q   <= ind_of(nxt);
      strb_q  <= accept;
    end
  end

  assign state_o = state_q;
  assign ind_o   = ind_q;
  assign strb_o  = strb_q;

  p_ind_legal_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    (ind_q == IND_DOWN) || (ind_q == IND_UP) || (ind_q == IND_ACT));
  p_strobe_single_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    strb_q |=> !strb_q);
  p_ar_ignored_armed_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    (state_q == PS_DOWN && armed_i && is_ar) |=> !strb_q);
  p_di_to_down_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    (state_q != PS_DOWN && is_di) |=> (ind_q == IND_DOWN));
endmodule

// File: rtl/ipsc_gate.sv
module ipsc_gate (
  input  logic clk_i,
  input  logic rst_i,
  input  logic want_on_i,
  input  logic tick_i,
  output logic clk_en_o,
  output logic frm_en_o
);
  logic clk_q, frm_q;

  // on: clock first, frame one tick later; off: frame first, clock later
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      clk_q <= 1'b1;
      frm_q <= 1'b1;
    end else if (tick_i) begin
      if (want_on_i) begin
        clk_q <= 1'b1;
        frm_q <= clk_q;
      end else begin
        frm_q <= 1'b0;
        clk_q <= frm_q;
      end
    end
  end

  assign clk_en_o = clk_q;
  assign frm_en_o = frm_q;

  p_hold_between_ticks_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    !tick_i |=> $stable({clk_q, frm_q}));
  p_frame_needs_clock_r10: assert property (@(posedge clk_i) disable iff (rst_i)
    frm_q |-> clk_q);
endmodule

// File: rtl/ifc_pwr_ctrl.sv
module ifc_pwr_ctrl
  import ipsc_pkg::*;
#(
  parameter int CODE_W = 4,
  parameter logic [CODE_W-1:0] CMD_TIM  = 4'b0000,
  parameter logic [CODE_W-1:0] CMD_AR   = 4'b1000,
  parameter logic [CODE_W-1:0] CMD_DI   = 4'b1111,
  parameter logic [CODE_W-1:0] IND_DOWN = 4'b1111,
  parameter logic [CODE_W-1:0] IND_UP   = 4'b0111,
  parameter logic [CODE_W-1:0] IND_ACT  = 4'b0100
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              clk_stop_cfg_i,
  input  logic              sw_pwr_up_i,
  input  logic              cmd_valid_i,
  input  logic [CODE_W-1:0] cmd_i,
  input  logic              frame_tick_i,
  output logic              clk_en_o,
  output logic              frm_en_o,
  output logic [CODE_W-1:0] ind_o,
  output logic              act_req_o
);
  logic    armed;
  pstate_t state;
  logic    want_on;

  ipsc_mode_track u_mode (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .cfg_i   (clk_stop_cfg_i),
    .armed_o (armed)
  );

  ipsc_state_fsm #(
    .CODE_W(CODE_W), .CMD_TIM(CMD_TIM), .CMD_AR(CMD_AR), .CMD_DI(CMD_DI),
    .IND_DOWN(IND_DOWN), .IND_UP(IND_UP), .IND_ACT(IND_ACT)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .armed_i     (armed),
    .cfg_i       (clk_stop_cfg_i),
    .sw_pwr_up_i (sw_pwr_up_i),
    .cmd_valid_i (cmd_valid_i),
    .cmd_i       (cmd_i),
    .state_o     (state),
    .ind_o       (ind_o),
    .strb_o      (act_req_o)
  );

  assign want_on = !(armed && state == PS_DOWN);

  ipsc_gate u_gate (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .want_on_i (want_on),
    .tick_i    (frame_tick_i),
    .clk_en_o  (clk_en_o),
    .frm_en_o  (frm_en_o)
  );

  p_unarmed_clock_on_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    (!armed && !clk_en_o && frame_tick_i) |=> clk_en_o);
endmodule

// File: tb/tb_ifc_pwr_ctrl.sv
module tb_ifc_pwr_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg = 1'b0;
  logic       spu = 1'b0;
  logic       cv  = 1'b0;
  logic [3:0] cmd = 4'h0;
  logic       tick = 1'b0;
  logic       clk_en, frm_en, act_req;
  logic [3:0] ind;

  int checks = 0;
  int failures = 0;
  int tcnt = 0;

  // behavioural reference state
  int m_st = 0;          // 0 down, 1 up, 2 activation requested
  bit m_arm = 0, m_cfgq = 1, m_clk = 1, m_frm = 1, m_strb = 0;

  ifc_pwr_ctrl dut (
    .clk_i(clk), .rst_i(rst), .clk_stop_cfg_i(cfg), .sw_pwr_up_i(spu),
    .cmd_valid_i(cv), .cmd_i(cmd), .frame_tick_i(tick),
    .clk_en_o(clk_en), .frm_en_o(frm_en), .ind_o(ind), .act_req_o(act_req)
  );

  always #2.5 clk = ~clk;

  always @(negedge clk) begin
    tcnt <= (tcnt + 1) % 4;
    tick <= (tcnt == 3);
  end

  function automatic logic [3:0] m_ind(int s);
    return (s == 1) ? 4'b0111 : (s == 2) ? 4'b0100 : 4'b1111;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_st = 0; m_arm = 0; m_cfgq = 1; m_clk = 1; m_frm = 1; m_strb = 0;
    end else begin
      bit want;
      bit oc, of;
      want = !(m_arm && m_st == 0);
      oc = m_clk; of = m_frm;
      m_strb = 0;
      if (m_st == 0) begin
        if (m_arm) begin
          if (spu || !cfg) m_st = 1;
        end else if (cv && cmd == 4'h0) m_st = 1;
        else if (cv && cmd == 4'h8) begin m_st = 2; m_strb = 1; end
      end else if (m_st == 1) begin
        if (cv && cmd == 4'hF) m_st = 0;
        else if (cv && cmd == 4'h8) begin m_st = 2; m_strb = 1; end
      end else begin
        if (cv && cmd == 4'hF) m_st = 0;
      end
      m_arm = cfg && (m_arm || !m_cfgq);
      m_cfgq = cfg;
      if (tick) begin
        if (want) begin m_clk = 1; m_frm = oc; end
        else begin m_frm = 0; m_clk = of; end
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // wait for the next falling edge, compare all outputs to the model, release pulses
  task automatic step();
    @(negedge clk);
    chk("R2 indication", ind, m_ind(m_st));
    chk("R6 strobe", act_req, m_strb);
    chk("R9 clock enable", clk_en, m_clk);
    chk("R10 frame enable", frm_en, m_frm);
    cv = 1'b0;
    spu = 1'b0;
  endtask

  task automatic issue(logic [3:0] c);
    cv = 1'b1; cmd = c;
    step();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    lf = 16'hACE1;
    idle(3);
    chk("R1 reset ind", ind, 4'hF);
    chk("R1 reset clk_en", clk_en, 1);
    chk("R1 reset frm_en", frm_en, 1);
    chk("R1 reset strobe", act_req, 0);
    rst = 1'b0;
    step();
    chk("R1 first cycle ind", ind, 4'hF);
    // clock-stop not armed
    issue(4'h0);
    chk("R4 timing to power-up", ind, 4'h7);
    idle(8);
    chk("R4 clocks on in power-up", clk_en, 1);
    issue(4'hF);
    chk("R5 deactivate to down", ind, 4'hF);
    idle(8);
    chk("R4 clocks on in power-down", clk_en & frm_en, 1);
    issue(4'h8);
    chk("R5 activate direct from down", ind, 4'h4);
    chk("R6 strobe on accept", act_req, 1);
    step();
    chk("R6 strobe single cycle", act_req, 0);
    issue(4'h8);
    chk("R6 no strobe when already requested", act_req, 0);
    issue(4'h5);
    chk("R3 unused code ignored", ind, 4'h4);
    cmd = 4'hF; step();
    chk("R3 invalid qualifier ignored", ind, 4'h4);
    issue(4'hF);
    chk("R5 deactivate from requested", ind, 4'hF);
    // arm clock-stop
    cfg = 1'b1;
    idle(12);
    chk("R8 clock stopped in down", clk_en, 0);
    chk("R8 frame stopped in down", frm_en, 0);
    issue(4'h0);
    chk("R8 timing ignored while stopped", ind, 4'hF);
    issue(4'h8);
    chk("R8 activate ignored while stopped", ind, 4'hF);
    chk("R8 no strobe while stopped", act_req, 0);
    idle(4);
    chk("R8 still stopped", clk_en, 0);
    spu = 1'b1; step();
    chk("R8 software power-up", ind, 4'h7);
    idle(12);
    chk("R10 both on after power-up", clk_en & frm_en, 1);
    issue(4'h8);
    chk("R5 activate from power-up", ind, 4'h4);
    issue(4'hF);
    idle(12);
    chk("R8 stopped again", clk_en, 0);
    cfg = 1'b0; step();
    chk("R8 clear config powers up", ind, 4'h7);
    idle(12);
    chk("R7 disarmed clocks on", clk_en, 1);
    // configuration held high through reset must not arm
    rst = 1'b1; cfg = 1'b1; idle(3);
    rst = 1'b0; idle(12);
    chk("R7 held config does not arm", clk_en, 1);
    chk("R7 state after reset", ind, 4'hF);
    // pseudo-random phase
    for (int i = 0; i < 3000; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      cv = lf[0] & lf[3];
      case (lf[6:5])
        2'd0: cmd = 4'h0;
        2'd1: cmd = 4'h8;
        2'd2: cmd = 4'hF;
        default: cmd = 4'h5;
      endcase
      spu = (lf[11:8] == 4'h0);
      if (lf[15:12] == 4'h9) cfg = ~cfg;
      step();
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule